// File: doc/BRIEF.md
# LIN Break Detection Status Unit

This block watches the receive line of a single-wire LIN bus and reports bus timing events to software. A 12-bit low-time counter advances on each prescaler tick while the synchronized line is low. When the count reaches a programmable threshold, the block marks a valid break. When the counter overflows, it marks a break-field error, because the line has stayed low for too long. A second timer restarts on each falling edge and is matched against its own compare value, so software can time the synchronization field.

The block also flags these events:
- a start condition (a falling edge),
- a stop condition (the line high for a fixed number of ticks after a low period),
- a rising edge, only when the alternate bus mode is on,
- completion of a soft reset.

All flags sit in a 32-bit status word. Each flag stays set until software reads the word. A masked interrupt request is formed from three of the flags. Frame decoding, baud-rate work and the UART datapath sit outside this block.

Top module: `lin_brk_mon`

## Requirements
- R1: After `rst_n` is asserted, `status_o` is 0 and `irq_o` is 0. Bits 31 to 7 of `status_o` always read 0.
- R2: Break-timer counting.
  - The break timer counts `tick_i` pulses while the synchronized bus is low. It clears when the bus is high.
  - Bit 0 (valid break) is set when the count reaches `brk_cmp_i`. A compare value of 0 never matches.
  - With `tick_i` held high, if `rxd_i` is driven low just after a clock edge, bit 0 is visible after clock edge number `brk_cmp_i`+2.
  - With `tick_i` held low, the timer does not advance.
- R3: Break-timer overflow.
  - Bit 3 (break error) is set when the timer is at 4095 and receives another tick. With `tick_i` high, this happens on edge 4098 after `rxd_i` is driven low.
  - Bit 3 is reported once per low period. The count saturates until the bus goes high.
- R4: Synchronization timer.
  - The timer restarts from 0 on each falling edge of the synchronized bus. It counts ticks up to 4095 and holds there.
  - Bit 2 (compare) is set when the timer reaches `sync_cmp_i`. This is visible after edge `sync_cmp_i`+3 following the low drive. A compare value of 0 never matches.
- R5: Bit 1 (start condition) is set on a falling edge of the synchronized bus. It is visible after the third clock edge following the low drive.
- R6: Stop condition.
  - Bit 4 (stop condition) is set when the bus has been high for STOP_TICKS ticks after a low period. It is visible after edge STOP_TICKS+2 following the high drive.
  - The detector then disarms until the next falling edge.
- R7: Bit 6 (rising edge) is set on a rising edge of the synchronized bus only while `alt_mode_i` is 1. It is visible after the third edge following the high drive. With `alt_mode_i` at 0, bit 6 stays 0.
- R8: Read-to-clear.
  - A one-cycle pulse on `rd_i` clears every flag at the next clock edge.
  - A flag whose event occurs at that same edge stays set.
- R9: Without a read or a soft reset, no flag ever goes from 1 to 0.
- R10: Soft reset.
  - While `srst_i` is 1, both timers and the stop detector are cleared, and all flags except bit 5 are 0.
  - At the first clock edge with `srst_i` back at 0, bit 5 (reset complete) is set.
- R11: Interrupt.
  - `irq_o` is 1 when at least one of these pairs is set: bit 0 with `irq_en_i[0]`, bit 2 with `irq_en_i[1]`, or bit 3 with `irq_en_i[2]`.
  - The other flags never raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count enable for both timers and the stop detector |
| rxd_i | input | 1 | Asynchronous LIN receive line |
| alt_mode_i | input | 1 | Enables the rising-edge flag |
| srst_i | input | 1 | Soft reset, level sensitive |
| rd_i | input | 1 | Status read strobe, one cycle |
| brk_cmp_i | input | 12 | Valid-break threshold |
| sync_cmp_i | input | 12 | Synchronization timer compare value |
| irq_en_i | input | 3 | Interrupt enables: [0] valid break, [1] compare, [2] break error |
| status_o | output | 32 | Sticky status word, bits 6..0 used |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions hold on every cycle for four properties:
- reserved bits stay at zero,
- no flag drops without a read or a soft reset,
- a soft reset leaves only the reset-complete flag possibly set,
- the rising-edge flag appears only in the alternate mode, and the interrupt stays low with all enables off.

The exact cycle on which each timer flag appears can only be shown by the bench scenarios. The same holds for the one-shot nature of the overflow, the read that coincides with an event, and the tick gating, because each depends on a stimulus history.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  localparam int unsigned NFLAGS      = 7;
  localparam int unsigned STAT_W      = 32;
  localparam int unsigned FLG_BRK     = 0;
  localparam int unsigned FLG_START   = 1;
  localparam int unsigned FLG_CMP     = 2;
  localparam int unsigned FLG_ERR     = 3;
  localparam int unsigned FLG_STOP    = 4;
  localparam int unsigned FLG_RSTDONE = 5;
  localparam int unsigned FLG_RISE    = 6;
endpackage

// File: rtl/lin_rx_cond.sv
// Input synchronizer, edge detection and stop-condition detector.
module lin_rx_cond #(
  parameter int unsigned STOP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic tick_i,
  input  logic rxd_i,
  output logic rx_low_o,
  output logic fall_o,
  output logic rise_o,
  output logic stop_o
);
  localparam int unsigned SC_W = $clog2(STOP_TICKS + 1);

  logic            s1_q, s2_q, prev_q;
  logic [SC_W-1:0] hcnt_q, hcnt_d;
  logic            armed_q, armed_d;
  logic            stop_ev;

  assign fall_o   = prev_q & ~s2_q;
  assign rise_o   = ~prev_q & s2_q;
  assign rx_low_o = ~s2_q;
  assign stop_o   = stop_ev;

  always_comb begin
    hcnt_d  = hcnt_q;
    armed_d = armed_q;
    stop_ev = 1'b0;
    if (srst_i) begin
      hcnt_d  = '0;
      armed_d = 1'b0;
    end else if (!s2_q) begin
      hcnt_d  = '0;
      if (fall_o) armed_d = 1'b1;
    end else if (tick_i && armed_q) begin
      if (hcnt_q == SC_W'(STOP_TICKS - 1)) begin
        stop_ev = 1'b1;
        armed_d = 1'b0;
        hcnt_d  = '0;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      hcnt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      s1_q    <= rxd_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      hcnt_q  <= hcnt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/lin_brk_timer.sv
// Low-time counter: threshold hit and one-shot overflow.
module lin_brk_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic         tick_i,
  input  logic         rx_low_i,
  input  logic [W-1:0] cmp_i,
  output logic         hit_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         sat_q, sat_d;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    sat_d = sat_q;
    hit_o = 1'b0;
    ovf_o = 1'b0;
    if (srst_i || !rx_low_i) begin
      cnt_d = '0;
      sat_d = 1'b0;
    end else if (tick_i) begin
      if (cnt_q == MAXV) begin
        if (!sat_q) begin
          ovf_o = 1'b1;
          sat_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_inc;
        hit_o = (cnt_inc == cmp_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sat_q <= sat_d;
    end
  end
endmodule

// File: rtl/lin_sync_timer.sv
// Synchronization timer restarted on each falling edge, saturating.
module lin_sync_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] cmp_i,
  output logic         hit_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (srst_i || restart_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != MAXV)) begin
      cnt_d = cnt_inc;
      hit_o = (cnt_inc == cmp_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lin_stat_reg.sv
// Sticky read-to-clear flags and masked interrupt.
module lin_stat_reg
  import lin_brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              rd_i,
  input  logic [NFLAGS-1:0] ev_i,
  input  logic [2:0]        irq_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [NFLAGS-1:0] KEEP = NFLAGS'(1) << FLG_RSTDONE;

  logic [NFLAGS-1:0] flg_q, flg_d, ev_all, rd_mask;
  logic              srst_q;

  always_comb begin
    ev_all              = ev_i;
    ev_all[FLG_RSTDONE] = ev_i[FLG_RSTDONE] | (srst_q & ~srst_i);
    rd_mask             = rd_i ? '0 : '1;
    if (srst_i) flg_d = flg_q & rd_mask & KEEP;
    else        flg_d = (flg_q & rd_mask) | ev_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      flg_q  <= flg_d;
      srst_q <= srst_i;
    end
  end

  assign status_o = {{(STAT_W-NFLAGS){1'b0}}, flg_q};
  assign irq_o    = (flg_q[FLG_BRK] & irq_en_i[0])
                  | (flg_q[FLG_CMP] & irq_en_i[1])
                  | (flg_q[FLG_ERR] & irq_en_i[2]);
endmodule

// File: rtl/lin_brk_mon.sv
// Top: LIN break detection status unit. rst_n is expected to be released
// synchronously by the surrounding reset logic.
module lin_brk_mon
  import lin_brk_pkg::*;
#(
  parameter int unsigned TMR_W      = 12,
  parameter int unsigned STOP_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              alt_mode_i,
  input  logic              srst_i,
  input  logic              rd_i,
  input  logic [TMR_W-1:0]  brk_cmp_i,
  input  logic [TMR_W-1:0]  sync_cmp_i,
  input  logic [2:0]        irq_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic rx_low, fall, rise, stop, brk_hit, brk_ovf, sync_hit;
  logic [NFLAGS-1:0] ev;

  lin_rx_cond #(.STOP_TICKS(STOP_TICKS)) u_cond (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .tick_i(tick_i), .rxd_i(rxd_i),
    .rx_low_o(rx_low), .fall_o(fall), .rise_o(rise), .stop_o(stop)
  );

  lin_brk_timer #(.W(TMR_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .tick_i(tick_i),
    .rx_low_i(rx_low), .cmp_i(brk_cmp_i), .hit_o(brk_hit), .ovf_o(brk_ovf)
  );

  lin_sync_timer #(.W(TMR_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .tick_i(tick_i),
    .restart_i(fall), .cmp_i(sync_cmp_i), .hit_o(sync_hit)
  );

  always_comb begin
    ev              = '0;
    ev[FLG_BRK]     = brk_hit;
    ev[FLG_START]   = fall;
    ev[FLG_CMP]     = sync_hit;
    ev[FLG_ERR]     = brk_ovf;
    ev[FLG_STOP]    = stop;
    ev[FLG_RSTDONE] = 1'b0;   // produced inside the status register
    ev[FLG_RISE]    = rise & alt_mode_i;
  end

  lin_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .rd_i(rd_i), .ev_i(ev),
    .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/lin_brk_mon_chk.sv
module lin_brk_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        srst_i,
  input logic        rd_i,
  input logic        alt_mode_i,
  input logic [2:0]  irq_en_i,
  input logic [31:0] status_o,
  input logic        irq_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:7] == '0);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !srst_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> ((status_o & ~32'h20) == 32'h0));

  // R7
  rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[6]) |-> $past(alt_mode_i));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i == 3'b000) |-> !irq_o);
endmodule

bind lin_brk_mon lin_brk_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst_i(srst_i), .rd_i(rd_i),
  .alt_mode_i(alt_mode_i), .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/lin_brk_mon_bench.sv
module lin_brk_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STOP       = 8;

  logic        clk = 1'b0;
  logic        rst_n, tick, rxd, alt, srst, rd, irq;
  logic [11:0] brk_cmp, sync_cmp;
  logic [2:0]  en;
  logic [31:0] status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_brk_mon #(.TMR_W(12), .STOP_TICKS(STOP)) u_lin_brk_mon (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd), .alt_mode_i(alt),
    .srst_i(srst), .rd_i(rd), .brk_cmp_i(brk_cmp), .sync_cmp_i(sync_cmp),
    .irq_en_i(en), .status_o(status), .irq_o(irq)
  );

  // Table: low time in cycles, break threshold, expected status while low
  localparam int NV = 6;
  localparam int V_LEN [NV] = '{10, 9, 30, 6, 7, 50};
  localparam int V_CMP [NV] = '{ 8, 8,  5, 5, 5, 100};
  localparam int V_EXP [NV] = '{ 3, 2,  3, 2, 3, 2};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    step(1);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; rxd = 1'b1; alt = 1'b0; srst = 1'b0; rd = 1'b0;
    brk_cmp = 12'd0; sync_cmp = 12'd0; en = 3'b000;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 status after reset", status, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 / R5 table of low periods against thresholds
    for (int i = 0; i < NV; i++) begin
      brk_cmp = 12'(V_CMP[i]);
      rxd = 1'b0;
      step(V_LEN[i]);
      chk("R2 R5 table break/start", status, 32'(V_EXP[i]));
      rxd = 1'b1;
      step(STOP + 4);
      do_read();
      chk("R8 cleared after read", status, 32'h0);
    end

    // R6 stop condition timing
    brk_cmp = 12'd200;
    rxd = 1'b0; step(5); do_read();
    rxd = 1'b1; step(STOP + 1);
    chk("R6 no stop yet", status, 32'h0);
    step(1);
    chk("R6 stop set", status, 32'h10);

    // R8 read at the same edge as a start event
    rxd = 1'b0; step(2);
    rd = 1'b1; step(1); rd = 1'b0;
    chk("R8 event wins over read", status, 32'h02);
    rxd = 1'b1; step(STOP + 4);
    // R7 alt mode off: rising edge leaves bit 6 clear
    chk("R7 no rise flag without alt mode", status, 32'h12);
    do_read();

    // R7 alt mode on
    alt = 1'b1;
    rxd = 1'b0; step(5); do_read();
    rxd = 1'b1; step(3);
    chk("R7 rise flag in alt mode", status & 32'h40, 32'h40);
    step(STOP + 2); do_read(); alt = 1'b0;

    // R4 sync timer compare
    step(30);
    sync_cmp = 12'd15;
    rxd = 1'b0; step(17);
    chk("R4 compare not yet", status & 32'h4, 32'h0);
    step(1);
    chk("R4 compare set", status & 32'h4, 32'h4);
    en = 3'b010; #1;
    chk("R11 irq on compare", {31'b0, irq}, 32'h1);
    en = 3'b101; #1;
    chk("R11 compare masked", {31'b0, irq}, 32'h0);
    en = 3'b000;
    @(negedge clk);
    rxd = 1'b1; step(STOP + 4); do_read(); sync_cmp = 12'd0;

    // R11 break interrupt gating
    brk_cmp = 12'd10;
    rxd = 1'b0; step(12);
    chk("R2 break flag", status & 32'h1, 32'h1);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    en = 3'b001; #1;
    chk("R11 irq on break", {31'b0, irq}, 32'h1);
    en = 3'b000;
    @(negedge clk);
    rxd = 1'b1; step(STOP + 4); do_read();

    // R2 tick gating: no ticks, no break
    tick = 1'b0;
    rxd = 1'b0; step(40);
    chk("R2 no count without ticks", status, 32'h02);
    tick = 1'b1;
    rxd = 1'b1; step(STOP + 4); do_read();

    // R3 overflow once
    brk_cmp = 12'd0; en = 3'b100;
    rxd = 1'b0; step(4097);
    chk("R3 no overflow yet", status & 32'h8, 32'h0);
    step(1);
    chk("R3 overflow flag", status, 32'h0A);
    chk("R11 irq on error", {31'b0, irq}, 32'h1);
    do_read();
    step(50);
    chk("R3 overflow reported once", status, 32'h0);
    chk("R3 irq gone after read", {31'b0, irq}, 32'h0);
    en = 3'b000;

    // R10 soft reset
    rxd = 1'b1; step(STOP + 4);
    chk("R6 stop before soft reset", status, 32'h10);
    srst = 1'b1; step(1);
    chk("R10 flags cleared in soft reset", status, 32'h0);
    step(3);
    srst = 1'b0; step(1);
    chk("R10 reset complete flag", status, 32'h20);
    do_read();
    chk("R8 R1 clear after read", status, 32'h0);
    chk("R1 reserved bits zero", status & 32'hFFFF_FF80, 32'h0);

    finish_run();
  end
endmodule